// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block sequences a 16-bit successive-approximation conversion. Two external handshake signals drive it: a sample strobe and a slow conversion clock. A fast system clock runs the block, and it synchronises both handshake signals into that domain.

While the strobe is high, the analog front end tracks its input. When the strobe falls after a valid high time, the block tells the front end to hold. Once the strobe has stayed low long enough, the block raises its busy flag and starts the approximation. The block ignores conversion-clock edges that arrive during a settle window after the strobe falls. After that window, each accepted edge resolves one bit, most significant bit first. The bit is decided from a comparator that is driven by the block's trial word.

The seventeenth accepted edge does three things. It adds a signed correction for each of the top result bits that is set. It loads the clamped sum into the parallel output register. It drops the busy flag.

The correction entries are loaded through a small write port by whatever runs calibration. That port is locked while a conversion is in progress.

Top module: `sar_handshake_ctrl`

## Requirements
- R1: After reset, `busy_o` and `hold_o` are 0 and `result_o` is 0x8000, which is offset-binary midscale (zero input).
- R2: If the strobe is high for at least MIN_HIGH synchronised cycles and then low for at least MIN_LOW cycles, `busy_o` rises. `busy_o` is still 0 two cycles after the strobe falls, and it is 1 within 20 cycles of the fall.
- R3: A strobe that is high for fewer than MIN_HIGH cycles starts no conversion. A low phase shorter than MIN_LOW, followed by the strobe going high again, also starts no conversion. In that second case, acquisition restarts and a later valid fall converts normally.
- R4: While `busy_o` is 1, the block ignores the strobe: toggling it changes neither the result nor the number of clocks that the conversion needs.
- R5: Rising edges of `conv_clk_i` seen within SETTLE system cycles after the strobe fall is detected are not counted.
- R6: A conversion takes exactly 17 counted conversion-clock edges. After 16 edges, `busy_o` is still 1 and `result_o` still holds the previous word. On the 17th edge, `result_o` loads and `busy_o` falls in the same cycle. `result_o` never changes at any other time.
- R7: `trial_o` is 0x8000 when `busy_o` rises. On counted edges 1 to 16, bit 15-k+1 is kept if `comp_i` is 1 and cleared if it is 0, and the next lower bit is then set. With all corrections zero, `result_o` equals the held input code.
- R8: Correction entry i is a CW-bit two's-complement value. It is added when bit 15-i of the raw code is set. The sum is clamped to the range 0x0000..0xFFFF.
- R9: Once `busy_o` is 0, further conversion-clock edges leave `result_o` and `busy_o` unchanged.
- R10: A correction write issued while `busy_o` is 1 is discarded. Neither the current conversion nor any later conversion uses it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_i | input | 1 | Sample strobe: high tracks, a falling edge commits |
| conv_clk_i | input | 1 | External conversion clock |
| comp_i | input | 1 | Comparator: 1 when the held input is at least `trial_o` |
| corr_we_i | input | 1 | Correction entry write enable |
| corr_idx_i | input | IW | Correction entry index (entry i belongs to bit 15-i) |
| corr_val_i | input | CW | Signed correction value |
| busy_o | output | 1 | Conversion in progress |
| hold_o | output | 1 | Front end holds its sample |
| trial_o | output | DW | Trial word fed to the comparator DAC |
| result_o | output | DW | Corrected, latched offset-binary result |

## Verification
Several rules hold on every cycle, and the assertions check them continuously. The result moves only together with the fall of busy. Busy falls only right after an accepted clock edge, and the trial word starts at midscale. Once the settle window is over, the trial word changes only after that window. The correction table cannot change during a conversion.

Other behaviour depends on how pulses are built, so only the bench's scenarios show it. That covers rejecting strobes that are too short, ignoring the strobe while busy, discarding early clock edges, and counting exactly seventeen edges. It also covers the bit decisions themselves and the corrected, clamped output values, which the bench checks against a behavioural sample-and-hold and comparator.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_TRACK  = 2'd1,
    ST_COMMIT = 2'd2,
    ST_CONV   = 2'd3
  } sar_state_t;
endpackage

// File: rtl/sar_in_sync.sv
module sar_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic rise
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], din};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign lvl  = sh_q[STAGES-1];
  assign rise = sh_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/sar_corr_bank.sv
module sar_corr_bank #(
  parameter int DW    = 16,
  parameter int NCORR = 8,
  parameter int CW    = 6,
  localparam int IW   = $clog2(NCORR)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [IW-1:0]          idx,
  input  logic [CW-1:0]          val,
  input  logic                   lock,
  input  logic [DW-1:0]          raw,
  output logic [DW-1:0]          corrected,
  output logic [NCORR*CW-1:0]    tab_flat
);
  localparam int SSW = DW + 2;

  logic [NCORR-1:0][CW-1:0] tab_q;
  logic signed [SSW-1:0]    acc;

  for (genvar g = 0; g < NCORR; g++) begin : g_entry
    logic wr_en;
    assign wr_en = we && !lock && (idx == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     tab_q[g] <= '0;
      else if (wr_en) tab_q[g] <= val;
    end
  end

  always_comb begin
    acc = {2'b00, raw};
    for (int i = 0; i < NCORR; i++) begin
      if (raw[DW-1-i]) acc = acc + {{(SSW-CW){tab_q[i][CW-1]}}, tab_q[i]};
    end
    if (acc[SSW-1])          corrected = '0;
    else if (acc[SSW-2])     corrected = '1;
    else                     corrected = acc[DW-1:0];
  end

  assign tab_flat = tab_q;
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int DW       = 16,
  parameter int MIN_HIGH = 4,
  parameter int MIN_LOW  = 3,
  parameter int SETTLE   = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_lvl,
  input  logic          s_rise,
  input  logic          ck_rise,
  input  logic          comp,
  output logic          busy,
  output logic          hold,
  output logic          load,
  output logic [DW-1:0] trial
);
  localparam int SW = $clog2(DW + 2);
  localparam int HW = $clog2(MIN_HIGH + 1);
  localparam int LW = $clog2(MIN_LOW + 1);
  localparam int TW = $clog2(SETTLE + 1);

  sar_state_t    st_q, st_d;
  logic [HW-1:0] hcnt_q, hcnt_d;
  logic [LW-1:0] lcnt_q, lcnt_d;
  logic [TW-1:0] scnt_q, scnt_d;
  logic [SW-1:0] step_q, step_d;
  logic [DW-1:0] trial_q, trial_d;
  logic [DW-1:0] cur_m, kept;
  logic          settled, counted;

  assign settled = (scnt_q == TW'(SETTLE));
  assign counted = (st_q == ST_CONV) && ck_rise && settled;
  assign cur_m   = {1'b1, {(DW-1){1'b0}}} >> step_q;
  assign kept    = comp ? trial_q : (trial_q & ~cur_m);

  always_comb begin
    st_d    = st_q;
    hcnt_d  = hcnt_q;
    lcnt_d  = lcnt_q;
    scnt_d  = scnt_q;
    step_d  = step_q;
    trial_d = trial_q;
    load    = 1'b0;
    if ((st_q == ST_COMMIT || st_q == ST_CONV) && !settled) scnt_d = scnt_q + 1'b1;
    case (st_q)
      ST_IDLE: begin
        if (s_rise) begin
          st_d   = ST_TRACK;
          hcnt_d = '0;
        end
      end
      ST_TRACK: begin
        if (!s_lvl) begin
          if (hcnt_q == HW'(MIN_HIGH)) begin
            st_d   = ST_COMMIT;
            lcnt_d = '0;
            scnt_d = '0;
          end else begin
            st_d = ST_IDLE;
          end
        end else if (hcnt_q != HW'(MIN_HIGH)) begin
          hcnt_d = hcnt_q + 1'b1;
        end
      end
      ST_COMMIT: begin
        if (s_lvl) begin
          st_d   = ST_TRACK;
          hcnt_d = '0;
        end else if (lcnt_q == LW'(MIN_LOW - 1)) begin
          st_d    = ST_CONV;
          step_d  = '0;
          trial_d = {1'b1, {(DW-1){1'b0}}};
        end else begin
          lcnt_d = lcnt_q + 1'b1;
        end
      end
      ST_CONV: begin
        if (counted) begin
          if (step_q == SW'(DW)) begin
            load = 1'b1;
            st_d = ST_IDLE;
          end else begin
            trial_d = kept | (cur_m >> 1);
            step_d  = step_q + 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      hcnt_q  <= '0;
      lcnt_q  <= '0;
      scnt_q  <= '0;
      step_q  <= '0;
      trial_q <= '0;
    end else begin
      st_q    <= st_d;
      hcnt_q  <= hcnt_d;
      lcnt_q  <= lcnt_d;
      scnt_q  <= scnt_d;
      step_q  <= step_d;
      trial_q <= trial_d;
    end
  end

  assign busy  = (st_q == ST_CONV);
  assign hold  = (st_q == ST_COMMIT) || (st_q == ST_CONV);
  assign trial = trial_q;
endmodule

// File: rtl/sar_handshake_ctrl.sv
module sar_handshake_ctrl #(
  parameter int DW       = 16,
  parameter int NCORR    = 8,
  parameter int CW       = 6,
  parameter int MIN_HIGH = 4,
  parameter int MIN_LOW  = 3,
  parameter int SETTLE   = 12,
  parameter int SYNC     = 2,
  localparam int IW      = $clog2(NCORR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_i,
  input  logic          conv_clk_i,
  input  logic          comp_i,
  input  logic          corr_we_i,
  input  logic [IW-1:0] corr_idx_i,
  input  logic [CW-1:0] corr_val_i,
  output logic          busy_o,
  output logic          hold_o,
  output logic [DW-1:0] trial_o,
  output logic [DW-1:0] result_o
);
  logic                s_lvl, s_rise;
  logic                ck_lvl, conv_rise;
  logic                busy, load;
  logic [DW-1:0]       trial, corrected;
  logic [DW-1:0]       result_q;
  logic [NCORR*CW-1:0] corr_flat;
  logic                ck_lvl_unused;

  sar_in_sync #(.STAGES(SYNC)) u_sync_sample (
    .clk(clk), .rst_n(rst_n), .din(sample_i), .lvl(s_lvl), .rise(s_rise)
  );

  sar_in_sync #(.STAGES(SYNC)) u_sync_clk (
    .clk(clk), .rst_n(rst_n), .din(conv_clk_i), .lvl(ck_lvl), .rise(conv_rise)
  );
  assign ck_lvl_unused = ck_lvl;

  sar_seq #(
    .DW(DW), .MIN_HIGH(MIN_HIGH), .MIN_LOW(MIN_LOW), .SETTLE(SETTLE)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .s_lvl(s_lvl), .s_rise(s_rise),
    .ck_rise(conv_rise), .comp(comp_i), .busy(busy), .hold(hold_o),
    .load(load), .trial(trial)
  );

  sar_corr_bank #(.DW(DW), .NCORR(NCORR), .CW(CW)) u_corr (
    .clk(clk), .rst_n(rst_n), .we(corr_we_i), .idx(corr_idx_i),
    .val(corr_val_i), .lock(busy), .raw(trial), .corrected(corrected),
    .tab_flat(corr_flat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    result_q <= {1'b1, {(DW-1){1'b0}}};
    else if (load) result_q <= corrected;
  end

  assign busy_o   = busy;
  assign trial_o  = trial;
  assign result_o = result_q;
endmodule

// File: rtl/sar_handshake_ctrl_chk.sv
module sar_handshake_ctrl_chk #(
  parameter int DW     = 16,
  parameter int NTAB   = 48,
  parameter int SETTLE = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            hold,
  input logic            ck_rise,
  input logic [DW-1:0]   trial,
  input logic [DW-1:0]   result,
  input logic [NTAB-1:0] tab
);
  localparam int CTW = $clog2(SETTLE + 2);
  logic [CTW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           cnt_q <= '0;
    else if (!hold)                       cnt_q <= '0;
    else if (cnt_q != CTW'(SETTLE + 1))   cnt_q <= cnt_q + 1'b1;
  end

  assert_result_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> $fell(busy));

  assert_fall_after_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(ck_rise));

  assert_trial_midscale_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> trial == {1'b1, {(DW-1){1'b0}}});

  assert_settle_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && !$stable(trial) |-> cnt_q > CTW'(SETTLE));

  assert_idle_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !$past(busy) |-> $stable(result));

  assert_table_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(tab));
endmodule

bind sar_handshake_ctrl sar_handshake_ctrl_chk #(
  .DW(DW), .NTAB(NCORR*CW), .SETTLE(SETTLE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy_o), .hold(hold_o),
  .ck_rise(conv_rise), .trial(trial_o), .result(result_o), .tab(corr_flat)
);

// File: tb/sar_handshake_ctrl_test.sv
module sar_handshake_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sample, conv_clk, we;
  logic [2:0]  idx;
  logic [5:0]  val;
  logic [15:0] vin, held;
  logic        busy, hold, comp;
  logic [15:0] trial, result;
  int          ntot = 0;
  int          nfail = 0;
  bit          done = 0;

  // {input code, expected result} with all corrections zero (R7)
  localparam logic [31:0] VECS [6] = '{
    32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_8000,
    32'h7FFF_7FFF, 32'h1234_1234, 32'hA5C3_A5C3
  };

  always #2.5 clk = ~clk;

  sar_handshake_ctrl uut (
    .clk(clk), .rst_n(rst_n), .sample_i(sample), .conv_clk_i(conv_clk),
    .comp_i(comp), .corr_we_i(we), .corr_idx_i(idx), .corr_val_i(val),
    .busy_o(busy), .hold_o(hold), .trial_o(trial), .result_o(result)
  );

  // behavioural sample-and-hold and comparator
  always @(posedge clk) if (!hold) held <= vin;
  assign comp = (held >= trial);

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    ntot++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cpulse(input int n);
    repeat (n) begin
      conv_clk = 1'b1; tick(4);
      conv_clk = 1'b0; tick(4);
    end
  endtask

  task automatic start(input logic [15:0] v);
    vin = v; sample = 1'b1; tick(10);
    sample = 1'b0; tick(20);
  endtask

  task automatic convert(input logic [15:0] v);
    start(v); cpulse(17); tick(4);
  endtask

  task automatic wr(input logic [2:0] i, input logic [5:0] v);
    we = 1'b1; idx = i; val = v; tick(1);
    we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      ntot++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", ntot - nfail, ntot);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sample = 1'b0; conv_clk = 1'b0; we = 1'b0;
    idx = '0; val = '0; vin = '0;
    tick(5);
    chk("R1 busy", busy, 0);
    chk("R1 hold", hold, 0);
    chk("R1 result", result, 32'h8000);
    rst_n = 1'b1; tick(3);

    for (int k = 0; k < 6; k++) begin
      convert(VECS[k][31:16]);
      chk("R7 code", result, VECS[k][15:0]);
      chk("R7 busy", busy, 0);
    end

    // R2: busy rises after a valid strobe
    vin = 16'h3C3C; sample = 1'b1; tick(10);
    sample = 1'b0; tick(2);
    chk("R2 early", busy, 0);
    tick(18);
    chk("R2 busy", busy, 1);
    cpulse(17); tick(4);
    chk("R2 result", result, 32'h3C3C);

    // R4 and R6: strobe toggled mid-conversion, edge count
    start(16'h1357);
    cpulse(5);
    sample = 1'b1; tick(10); sample = 1'b0; tick(3);
    cpulse(11); tick(4);
    chk("R6 busy16", busy, 1);
    chk("R6 old result", result, 32'h3C3C);
    cpulse(1); tick(4);
    chk("R6 busy17", busy, 0);
    chk("R4 result", result, 32'h1357);

    // R9: extra edges after completion
    cpulse(3); tick(4);
    chk("R9 result", result, 32'h1357);
    chk("R9 busy", busy, 0);

    // R5: edges inside the settle window
    vin = 16'h0F0F; sample = 1'b1; tick(10);
    sample = 1'b0; tick(1);
    cpulse(2); tick(12);
    cpulse(16); tick(4);
    chk("R5 busy16", busy, 1);
    cpulse(1); tick(4);
    chk("R5 result", result, 32'h0F0F);

    // R3: short high, short low
    sample = 1'b1; tick(2); sample = 1'b0; tick(20);
    chk("R3 short high busy", busy, 0);
    chk("R3 short high hold", hold, 0);
    vin = 16'h2222; sample = 1'b1; tick(10);
    sample = 1'b0; tick(1); sample = 1'b1; tick(10);
    chk("R3 short low", busy, 0);
    sample = 1'b0; tick(20);
    chk("R3 recommit", busy, 1);
    cpulse(17); tick(4);
    chk("R3 result", result, 32'h2222);

    // R8: corrections and clamping
    wr(3'd0, 6'h05); wr(3'd7, 6'h3D); wr(3'd1, 6'h20);
    convert(16'h8100);
    chk("R8 plus minus", result, 32'h8102);
    convert(16'h4000);
    chk("R8 negative", result, 32'h3FE0);
    convert(16'h00FF);
    chk("R8 low bits", result, 32'h00FF);
    wr(3'd0, 6'h1F); wr(3'd1, 6'h00); wr(3'd7, 6'h00);
    convert(16'hFFFF);
    chk("R8 clamp", result, 32'hFFFF);
    convert(16'hFFE0);
    chk("R8 clamp edge", result, 32'hFFFF);
    convert(16'h8000);
    chk("R8 msb", result, 32'h801F);

    // R10: write during conversion is dropped
    wr(3'd0, 6'h00);
    start(16'h8000);
    wr(3'd0, 6'h07);
    cpulse(17); tick(4);
    chk("R10 current", result, 32'h8000);
    convert(16'h8000);
    chk("R10 later", result, 32'h8000);

    done = 1;
    $display("%0d/%0d checks passed", ntot - nfail, ntot);
    $finish;
  end
endmodule